// File: doc/BRIEF.md
# Processor Status Flags Register

This block keeps the 16-bit processor status word of a small integer core and carries out every operation that touches only the flags. It sets, clears or inverts the carry flag. It sets or clears the direction flag and the interrupt-enable flag. It hands the low byte of the word out for an AH load, and it takes an AH value into that low byte. It restores the whole word from a value popped off the stack. It also latches the condition bits that an external ALU produces, under one of three masks. Arithmetic is done elsewhere; this unit only decides which flag bits may change and to what.

Each cycle carries at most one flag operation, chosen by a 4-bit code while `opValid` is high. A stack restore arrives on its own strobe and can share a cycle with an operation. The current word is always on `flagsWord`, and a flags push stores that value. The individual flag bits are also brought out as separate outputs. Several bit positions are fixed and ignore any write.

Top module: `flagsUnit`

## Requirements
- R1: After reset, `flagsWord` is 16'hF002 (every writable flag 0) and `ahOut` is 8'h00.
- R2: With `opValid` high, code 1 clears the carry bit (bit 0), code 2 sets it and code 3 inverts it. The new value is visible on the cycle after the clock edge, and no other bit changes.
- R3: Code 4 clears the direction bit (bit 10) and code 5 sets it. Code 6 clears the interrupt-enable bit (bit 9) and code 7 sets it. No other bit changes.
- R4: Code 8 captures the low byte of the word, as it stood before the edge, into `ahOut` and leaves the word unchanged. At every other time `ahOut` holds its value.
- R5: Code 9 writes `ahIn` into bits 7..0 and leaves bits 15..8 unchanged, subject to R7.
- R6: With `popValid` high, the whole word is replaced by `popWord`, subject to R7. `flagsWord` is the value to push.
- R7: Bit 1 always reads 1. Bits 3 and 5 always read 0. Bits 15..12 always read 1, whatever is written.
- R8: Code 10 loads `aluFlags` = {OF, SF, ZF, AF, PF, CF} (bits 5..0) into word bits 11, 7, 6, 4, 2 and 0. All other bits are unchanged.
- R9: Code 11, the logical-test update, changes only SF, ZF and PF (bit 7 from `aluFlags[4]`, bit 6 from `aluFlags[3]`, bit 2 from `aluFlags[1]`).
- R10: Code 12 loads OF, SF, ZF, AF and PF as in R8 and keeps CF unchanged.
- R11: When `popValid` and `opValid` are high in the same cycle, the restore wins and the flag operation is dropped. A code 8 still captures the word as it stood before that edge.
- R12: With `opValid` low, or with code 0 or 13..15, the word and `ahOut` are unchanged.
- R13: The single-bit outputs equal word bits CF=0, PF=2, AF=4, ZF=6, SF=7, TF=8, IF=9, DF=10 and OF=11. TF changes only through a restore.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Qualifies `opCode` this cycle |
| opCode | input | 4 | Flag operation code (R2 to R12) |
| ahIn | input | 8 | AH value for the store-low-byte operation |
| popValid | input | 1 | Restore the whole word from `popWord` |
| popWord | input | 16 | Word popped from the stack |
| aluFlags | input | 6 | ALU condition bits {OF,SF,ZF,AF,PF,CF} |
| flagsWord | output | 16 | Current status word, also the push value |
| ahOut | output | 8 | Low byte captured by the AH load |
| cfOut | output | 1 | Carry flag |
| pfOut | output | 1 | Parity flag |
| afOut | output | 1 | Auxiliary carry flag |
| zfOut | output | 1 | Zero flag |
| sfOut | output | 1 | Sign flag |
| tfOut | output | 1 | Trap flag |
| ifOut | output | 1 | Interrupt-enable flag |
| dfOut | output | 1 | Direction flag |
| ofOut | output | 1 | Overflow flag |

## Verification
A stack restore and an individual flag operation can both be requested in the same cycle. The same holds for a restore paired with the AH load, which reads the word while the restore rewrites it. The bench drives each of these pairs on purpose and also mixes them freely in a long stretch of random traffic. Each result is judged against a behavioural model in which the restore overwrites the word and the AH capture takes the value from before the edge.

// File: rtl/flagsPkg.sv
package flagsPkg;

  localparam int FLAGS_W = 16;
  localparam int BYTE_W  = 8;
  localparam int ALU_W   = 6;
  localparam int OP_W    = 4;

  // bit positions inside the status word
  localparam int CF_POS = 0;
  localparam int PF_POS = 2;
  localparam int AF_POS = 4;
  localparam int ZF_POS = 6;
  localparam int SF_POS = 7;
  localparam int TF_POS = 8;
  localparam int IF_POS = 9;
  localparam int DF_POS = 10;
  localparam int OF_POS = 11;

  // bits tied high / tied low regardless of writes
  localparam logic [FLAGS_W-1:0] FIXED_ONES  = 16'hF002;
  localparam logic [FLAGS_W-1:0] FIXED_ZEROS = 16'h0028;

  typedef enum logic [OP_W-1:0] {
    OP_IDLE      = 4'd0,
    OP_CLR_CARRY = 4'd1,
    OP_SET_CARRY = 4'd2,
    OP_CPL_CARRY = 4'd3,
    OP_CLR_DIR   = 4'd4,
    OP_SET_DIR   = 4'd5,
    OP_CLR_INT   = 4'd6,
    OP_SET_INT   = 4'd7,
    OP_LOAD_AH   = 4'd8,
    OP_STORE_AH  = 4'd9,
    OP_ALU_ARITH = 4'd10,
    OP_ALU_TEST  = 4'd11,
    OP_ALU_KEEPC = 4'd12
  } flagOpE;

  // ALU input bit i lands on this word position
  function automatic int aluPos(input int idx);
    case (idx)
      0:       return CF_POS;
      1:       return PF_POS;
      2:       return AF_POS;
      3:       return ZF_POS;
      4:       return SF_POS;
      default: return OF_POS;
    endcase
  endfunction

  // selection of ALU inputs -> word-wide write mask
  function automatic logic [FLAGS_W-1:0] aluMaskOf(input logic [ALU_W-1:0] sel);
    logic [FLAGS_W-1:0] m;
    m = '0;
    for (int i = 0; i < ALU_W; i++) m[aluPos(i)] = sel[i];
    return m;
  endfunction

  localparam logic [ALU_W-1:0] SEL_ARITH = 6'b111111;
  localparam logic [ALU_W-1:0] SEL_TEST  = 6'b011010;
  localparam logic [ALU_W-1:0] SEL_KEEPC = 6'b111110;

  typedef struct packed {
    logic               restore;
    logic               storeLow;
    logic               captureAh;
    logic [FLAGS_W-1:0] setMask;
    logic [FLAGS_W-1:0] clrMask;
    logic [FLAGS_W-1:0] tglMask;
    logic [FLAGS_W-1:0] aluMask;
  } strobeT;

endpackage

// File: rtl/flagCtrl.sv
module flagCtrl
  import flagsPkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            opValid,
  input  logic [OP_W-1:0] opCode,
  input  logic            popValid,
  output strobeT          strobes
);

  localparam logic [FLAGS_W-1:0] ONE_HOT_BASE = {{(FLAGS_W-1){1'b0}}, 1'b1};

  flagOpE opKind;
  assign opKind = flagOpE'(opCode);

  always_comb begin
    strobes = '0;
    // AH capture reads the old word, so it survives a restore
    strobes.captureAh = opValid && (opKind == OP_LOAD_AH);
    if (popValid) begin
      strobes.restore = 1'b1;
    end else if (opValid) begin
      case (opKind)
        OP_CLR_CARRY: strobes.clrMask = ONE_HOT_BASE << CF_POS;
        OP_SET_CARRY: strobes.setMask = ONE_HOT_BASE << CF_POS;
        OP_CPL_CARRY: strobes.tglMask = ONE_HOT_BASE << CF_POS;
        OP_CLR_DIR:   strobes.clrMask = ONE_HOT_BASE << DF_POS;
        OP_SET_DIR:   strobes.setMask = ONE_HOT_BASE << DF_POS;
        OP_CLR_INT:   strobes.clrMask = ONE_HOT_BASE << IF_POS;
        OP_SET_INT:   strobes.setMask = ONE_HOT_BASE << IF_POS;
        OP_STORE_AH:  strobes.storeLow = 1'b1;
        OP_ALU_ARITH: strobes.aluMask = aluMaskOf(SEL_ARITH);
        OP_ALU_TEST:  strobes.aluMask = aluMaskOf(SEL_TEST);
        OP_ALU_KEEPC: strobes.aluMask = aluMaskOf(SEL_KEEPC);
        default:      ;
      endcase
    end
  end

  // R11: a restore suppresses every per-flag write strobe
  assert_restore_exclusive_R11: assert property (@(posedge clk) disable iff (!rstN)
    popValid |-> !strobes.storeLow && (strobes.setMask == '0) && (strobes.clrMask == '0)
                 && (strobes.tglMask == '0) && (strobes.aluMask == '0));

  // R12: at most one kind of write per cycle, none when idle
  assert_one_write_kind_R12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.restore, strobes.storeLow, |strobes.setMask, |strobes.clrMask,
              |strobes.tglMask, |strobes.aluMask}));

  assert_idle_no_write_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!opValid && !popValid) |-> (strobes == '0));

endmodule

// File: rtl/flagData.sv
module flagData
  import flagsPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobeT             strobes,
  input  logic [BYTE_W-1:0]  ahIn,
  input  logic [FLAGS_W-1:0] popWord,
  input  logic [ALU_W-1:0]   aluFlags,
  output logic [FLAGS_W-1:0] flagsWord,
  output logic [BYTE_W-1:0]  ahOut
);

  logic [FLAGS_W-1:0] flagsQ, flagsNext, baseWord, aluWide;
  logic [BYTE_W-1:0]  ahQ;

  // spread ALU bits to their word positions
  always_comb begin
    aluWide = '0;
    for (int i = 0; i < ALU_W; i++) aluWide[aluPos(i)] = aluFlags[i];
  end

  always_comb begin
    if (strobes.restore)
      baseWord = popWord;
    else if (strobes.storeLow)
      baseWord = {flagsQ[FLAGS_W-1:BYTE_W], ahIn};
    else
      baseWord = ((flagsQ & ~strobes.clrMask) | strobes.setMask) ^ strobes.tglMask;
    baseWord  = (baseWord & ~strobes.aluMask) | (aluWide & strobes.aluMask);
    flagsNext = (baseWord | FIXED_ONES) & ~FIXED_ZEROS;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagsQ <= FIXED_ONES;
      ahQ    <= '0;
    end else begin
      flagsQ <= flagsNext;
      if (strobes.captureAh) ahQ <= flagsQ[BYTE_W-1:0];
    end
  end

  assign flagsWord = flagsQ;
  assign ahOut     = ahQ;

  assert_fixed_bits_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((flagsQ & FIXED_ONES) == FIXED_ONES) && ((flagsQ & FIXED_ZEROS) == '0));

  assert_restore_word_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.restore |=> flagsQ == (($past(popWord) | FIXED_ONES) & ~FIXED_ZEROS));

  assert_ah_capture_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.captureAh |=> ahQ == $past(flagsQ[BYTE_W-1:0]));

  assert_ah_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.captureAh |=> $stable(ahQ));

  assert_store_keeps_upper_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.storeLow |=> flagsQ[FLAGS_W-1:BYTE_W] == $past(flagsQ[FLAGS_W-1:BYTE_W]));

endmodule

// File: rtl/flagsUnit.sv
module flagsUnit
  import flagsPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         opValid,
  input  logic [3:0]   opCode,
  input  logic [7:0]   ahIn,
  input  logic         popValid,
  input  logic [15:0]  popWord,
  input  logic [5:0]   aluFlags,
  output logic [15:0]  flagsWord,
  output logic [7:0]   ahOut,
  output logic         cfOut,
  output logic         pfOut,
  output logic         afOut,
  output logic         zfOut,
  output logic         sfOut,
  output logic         tfOut,
  output logic         ifOut,
  output logic         dfOut,
  output logic         ofOut
);

  strobeT strobes;

  flagCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .opValid  (opValid),
    .opCode   (opCode),
    .popValid (popValid),
    .strobes  (strobes)
  );

  flagData u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .ahIn      (ahIn),
    .popWord   (popWord),
    .aluFlags  (aluFlags),
    .flagsWord (flagsWord),
    .ahOut     (ahOut)
  );

  assign cfOut = flagsWord[CF_POS];
  assign pfOut = flagsWord[PF_POS];
  assign afOut = flagsWord[AF_POS];
  assign zfOut = flagsWord[ZF_POS];
  assign sfOut = flagsWord[SF_POS];
  assign tfOut = flagsWord[TF_POS];
  assign ifOut = flagsWord[IF_POS];
  assign dfOut = flagsWord[DF_POS];
  assign ofOut = flagsWord[OF_POS];

  assert_carry_invert_R2: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !popValid && opCode == OP_CPL_CARRY) |=> cfOut != $past(cfOut));

  assert_test_scope_R9: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !popValid && opCode == OP_ALU_TEST)
      |=> $stable({cfOut, afOut, tfOut, ifOut, dfOut, ofOut}));

  assert_keepc_R10: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !popValid && opCode == OP_ALU_KEEPC) |=> $stable(cfOut));

  assert_trap_only_restore_R13: assert property (@(posedge clk) disable iff (!rstN)
    !popValid |=> $stable(tfOut));

endmodule

// File: tb/sim_flagsUnit.sv
module sim_flagsUnit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [3:0]  opCode = '0;
  logic [7:0]  ahIn = '0;
  logic        popValid = 1'b0;
  logic [15:0] popWord = '0;
  logic [5:0]  aluFlags = '0;
  logic [15:0] flagsWord;
  logic [7:0]  ahOut;
  logic cfOut, pfOut, afOut, zfOut, sfOut, tfOut, ifOut, dfOut, ofOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [15:0] refF;
  logic [7:0]  refA;

  always #5 clk = ~clk;

  flagsUnit u0 (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .ahIn(ahIn),
    .popValid(popValid), .popWord(popWord), .aluFlags(aluFlags),
    .flagsWord(flagsWord), .ahOut(ahOut), .cfOut(cfOut), .pfOut(pfOut),
    .afOut(afOut), .zfOut(zfOut), .sfOut(sfOut), .tfOut(tfOut), .ifOut(ifOut),
    .dfOut(dfOut), .ofOut(ofOut)
  );

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    chk(tag, "flagsWord", flagsWord, refF);
    chk(tag, "ahOut", {8'h00, ahOut}, {8'h00, refA});
    // R13 single-bit outputs
    chk("R13", "flag pins",
        {7'd0, ofOut, dfOut, ifOut, tfOut, sfOut, zfOut, afOut, pfOut, cfOut},
        {7'd0, refF[11], refF[10], refF[9], refF[8], refF[7], refF[6], refF[4], refF[2], refF[0]});
  endtask

  // behavioural reference: advance one clock
  task automatic modelStep(input logic v, input logic [3:0] c, input logic [7:0] ah,
                           input logic pv, input logic [15:0] pw, input logic [5:0] af);
    logic [15:0] nF;
    logic [7:0]  nA;
    nF = refF;
    nA = refA;
    if (v && c == 4'd8) nA = refF[7:0];
    if (pv) nF = pw;
    else if (v) begin
      case (c)
        4'd1:  nF[0] = 1'b0;
        4'd2:  nF[0] = 1'b1;
        4'd3:  nF[0] = ~nF[0];
        4'd4:  nF[10] = 1'b0;
        4'd5:  nF[10] = 1'b1;
        4'd6:  nF[9] = 1'b0;
        4'd7:  nF[9] = 1'b1;
        4'd9:  nF[7:0] = ah;
        4'd10: {nF[11], nF[7], nF[6], nF[4], nF[2], nF[0]} = af;
        4'd11: {nF[7], nF[6], nF[2]} = {af[4], af[3], af[1]};
        4'd12: {nF[11], nF[7], nF[6], nF[4], nF[2]} = af[5:1];
        default: ;
      endcase
    end
    nF[15:12] = 4'hF;
    nF[1] = 1'b1;
    nF[3] = 1'b0;
    nF[5] = 1'b0;
    refF = nF;
    refA = nA;
  endtask

  task automatic step(input logic v, input logic [3:0] c, input logic [7:0] ah,
                      input logic pv, input logic [15:0] pw, input logic [5:0] af,
                      input string tag);
    @(negedge clk);
    opValid = v; opCode = c; ahIn = ah; popValid = pv; popWord = pw; aluFlags = af;
    modelStep(v, c, ah, pv, pw, af);
    @(negedge clk);
    compareAll(tag);
    opValid = 1'b0; popValid = 1'b0;
  endtask

  initial begin
    refF = 16'hF002;
    refA = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    compareAll("R1");

    step(1, 4'd2, 8'h00, 0, 16'h0, 6'h0, "R2");
    step(1, 4'd3, 8'h00, 0, 16'h0, 6'h0, "R2");
    step(1, 4'd3, 8'h00, 0, 16'h0, 6'h0, "R2");
    step(1, 4'd1, 8'h00, 0, 16'h0, 6'h0, "R2");
    step(1, 4'd5, 8'h00, 0, 16'h0, 6'h0, "R3");
    step(1, 4'd7, 8'h00, 0, 16'h0, 6'h0, "R3");
    step(1, 4'd4, 8'h00, 0, 16'h0, 6'h0, "R3");
    step(1, 4'd6, 8'h00, 0, 16'h0, 6'h0, "R3");
    step(1, 4'd9, 8'hFF, 0, 16'h0, 6'h0, "R5");
    step(1, 4'd8, 8'h00, 0, 16'h0, 6'h0, "R4");
    step(0, 4'd2, 8'h00, 0, 16'h0, 6'h3F, "R12");
    step(1, 4'd14, 8'h55, 0, 16'h0, 6'h3F, "R12");
    step(1, 4'd0, 8'h55, 0, 16'h0, 6'h3F, "R12");
    step(0, 4'd0, 8'h00, 1, 16'h0000, 6'h0, "R7");
    step(0, 4'd0, 8'h00, 1, 16'hFFFF, 6'h0, "R6");
    step(1, 4'd10, 8'h00, 0, 16'h0, 6'b101010, "R8");
    step(1, 4'd11, 8'h00, 0, 16'h0, 6'b111111, "R9");
    step(1, 4'd11, 8'h00, 0, 16'h0, 6'b000000, "R9");
    step(1, 4'd12, 8'h00, 0, 16'h0, 6'b111110, "R10");
    step(1, 4'd2, 8'h00, 1, 16'h0000, 6'h0, "R11");
    step(1, 4'd9, 8'hFF, 1, 16'h0100, 6'h0, "R11");
    step(1, 4'd8, 8'h00, 1, 16'h00C5, 6'h0, "R11");
    step(1, 4'd8, 8'h00, 0, 16'h0, 6'h0, "R4");

    for (int i = 0; i < 400; i++) begin
      logic [3:0] c;
      c = 4'($urandom_range(0, 15));
      step(1'($urandom_range(0, 3) != 0), c, 8'($urandom), 1'($urandom_range(0, 4) == 0),
           16'($urandom), 6'($urandom), "R11");
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule